// File: doc/BRIEF.md
# Instrument Power Switch Overcurrent Guard

This block drives the power switch enables of a group of instruments and shuts a switch off by itself when its instrument draws too much current. Switches are turned on and off by commands. Each switch also has an override bit, set and cleared by commands. A register write sets the length of the inrush guardband shared by all instruments, and another register write clears latched trip flags.

Every time a switch is turned on, a guardband window opens for that instrument. Overcurrent reports are ignored while that window runs. Each overcurrent line is synchronized and must be confirmed before it counts. A confirmed overcurrent forces the switch off only when neither the guardband nor the override of that instrument is active. The switch then stays off and a sticky trip flag is set. While the trip flag is set, on-commands to that instrument are refused until software clears the flag.

Top module: `pwr_switch_guard`

## Requirements
- R1: After reset every switch enable, trip flag, override bit and guardband indicator is 0, and the guardband length reads 10.
- R2: A command with `cmd_op` = 2'b01 (on), addressed to an instrument that is off and not tripped, raises its switch enable on the next clock edge. Its guardband indicator stays high for exactly length × STEP_CYCLES cycles after that edge.
- R3: A write on `len_wr` loads `len_wdata` as the guardband length, in steps of STEP_CYCLES cycles. Values below 1 load 1 and values above 10 load 10, so `guard_len` always lies between 1 and 10.
- R4: An overcurrent input counts only once its synchronized level has been high on OC_RUN (default 4) consecutive clock edges. With the default settings, a pulse that spans 3 sampling edges has no effect on the switch or the trip flag.
- R5: Suppose an overcurrent input goes high before edge k and stays high, while its switch is on with no guardband and no override. Then the switch enable is still 1 after edge k+5 and is 0 after edge k+6, and at that same edge the trip flag of that instrument rises.
- R6: A confirmed overcurrent never trips an instrument while its guardband indicator is high. The trip follows on the second edge after the guardband ends if the overcurrent persists.
- R7: `cmd_op` = 2'b10 sets and 2'b11 clears the override bit of the addressed instrument on the next edge. While the override is set, overcurrent causes no trip. If the override is cleared while a confirmed overcurrent persists, the switch drops and trips on the edge after the override goes low.
- R8: A trip flag stays set until a write on `trip_clr_wr` with a 1 in that instrument's bit of `trip_clr_mask`, and it clears on the next edge. While the flag is set, on-commands to that instrument leave the switch off.
- R9: `cmd_op` = 2'b00 (off) turns the addressed switch off on the next edge and ends any guardband in progress at that same edge.
- R10: Each instrument's state changes only through commands addressed to its index, its own mask bit and its own overcurrent input. Commands whose `cmd_sel` is not below N_INST change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | 00 off, 01 on, 10 set override, 11 clear override |
| cmd_sel | input | SEL_W | Instrument index addressed by the command |
| len_wr | input | 1 | Guardband length register write strobe |
| len_wdata | input | 4 | Guardband length in steps, clamped to 1..10 |
| trip_clr_wr | input | 1 | Trip flag clear write strobe |
| trip_clr_mask | input | N_INST | Write-one-to-clear mask for trip flags |
| oc_in | input | N_INST | Asynchronous overcurrent status, one per instrument |
| sw_en | output | N_INST | Power switch enables |
| tripped | output | N_INST | Sticky trip flags |
| ovr_on | output | N_INST | Override bits |
| guard_busy | output | N_INST | Guardband window running |
| guard_len | output | 4 | Current guardband length in steps |

## Verification
A corrupted guardband counter shows up at the ports as a wrong `guard_busy` width, or as a trip arriving one edge too early or too late against a steady overcurrent. The bench therefore checks both edges of that window. If the run counter of the overcurrent filter is wrong, 3-edge glitches cause trips, or the trip edge moves away from k+6. Both are checked by exact-edge comparisons within ten cycles of the stimulus. A trip flag, override bit or switch bit that is wrong appears on its status output one edge after the command or write that should have set it. Side-effects on neighbouring instruments are caught by comparing their bits at the same edges.

// File: rtl/pwrg_pkg.sv
package pwrg_pkg;
  typedef enum logic [1:0] {
    OP_OFF     = 2'b00,
    OP_ON      = 2'b01,
    OP_OVR_SET = 2'b10,
    OP_OVR_CLR = 2'b11
  } pwr_op_e;

  localparam int GLEN_W   = 4;
  localparam int GLEN_MIN = 1;
  localparam int GLEN_MAX = 10;
endpackage

// File: rtl/pwrg_rst_sync.sv
module pwrg_rst_sync (
  input  logic clk,
  input  logic rst_an,
  output logic rst_sn
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb begin
    stage_d = {stage_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_an) begin
    if (!rst_an) stage_q <= 2'b00;
    else         stage_q <= stage_d;
  end

  assign rst_sn = stage_q[1];
endmodule

// File: rtl/pwrg_len_reg.sv
module pwrg_len_reg
  import pwrg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [GLEN_W-1:0] wdata,
  output logic [GLEN_W-1:0] len_q
);
  localparam logic [GLEN_W-1:0] LMIN = GLEN_W'(GLEN_MIN);
  localparam logic [GLEN_W-1:0] LMAX = GLEN_W'(GLEN_MAX);

  logic [GLEN_W-1:0] clamped;
  logic [GLEN_W-1:0] len_d;

  always_comb begin
    if (wdata < LMIN)      clamped = LMIN;
    else if (wdata > LMAX) clamped = LMAX;
    else                   clamped = wdata;
    len_d = wr_en ? clamped : len_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) len_q <= LMAX;
    else        len_q <= len_d;
  end

  assert_len_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (len_q >= LMIN) && (len_q <= LMAX));

  assert_write_lands_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata >= LMIN && wdata <= LMAX) |=> (len_q == $past(wdata)));
endmodule

// File: rtl/pwrg_oc_filter.sv
module pwrg_oc_filter #(
  parameter int RUN_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic oc_async,
  output logic oc_confirmed
);
  localparam int CW = $clog2(RUN_LEN + 1);
  localparam logic [CW-1:0] RUN_TOP = CW'(RUN_LEN);

  logic          s1_q, s2_q;
  logic [CW-1:0] run_q, run_d;

  always_comb begin
    if (!s2_q)                run_d = '0;
    else if (run_q == RUN_TOP) run_d = run_q;
    else                      run_d = run_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_q  <= 1'b0;
      s2_q  <= 1'b0;
      run_q <= '0;
    end else begin
      s1_q  <= oc_async;
      s2_q  <= s1_q;
      run_q <= run_d;
    end
  end

  assign oc_confirmed = (run_q == RUN_TOP);

  assert_confirm_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    oc_confirmed |-> (s2_q || $past(s2_q)) && $past(oc_confirmed || run_q != '0));

  assert_low_clears_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !s2_q |=> !oc_confirmed);
endmodule

// File: rtl/pwrg_channel.sv
module pwrg_channel
  import pwrg_pkg::*;
#(
  parameter int STEP_CYCLES = 167800,
  localparam int GCNT_W = $clog2(GLEN_MAX * STEP_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_hit,
  input  pwr_op_e           cmd_op,
  input  logic              clr_trip,
  input  logic              oc_ok,
  input  logic [GLEN_W-1:0] len,
  output logic              sw_en,
  output logic              tripped,
  output logic              ovr_on,
  output logic              guard_busy
);
  logic              sw_q, sw_d;
  logic              trip_q, trip_d;
  logic              ovr_q, ovr_d;
  logic [GCNT_W-1:0] g_q, g_d;
  logic [GCNT_W-1:0] load_val;
  logic              guard_live;
  logic              trip_now;

  assign load_val   = GCNT_W'(len) * GCNT_W'(STEP_CYCLES);
  assign guard_live = (g_q != '0);
  assign trip_now   = sw_q && oc_ok && !guard_live && !ovr_q;

  always_comb begin
    sw_d   = sw_q;
    trip_d = trip_q;
    ovr_d  = ovr_q;
    g_d    = guard_live ? g_q - GCNT_W'(1) : g_q;

    if (clr_trip) trip_d = 1'b0;

    if (cmd_hit) begin
      unique case (cmd_op)
        OP_OFF: begin
          sw_d = 1'b0;
          g_d  = '0;
        end
        OP_ON: begin
          if (!sw_q && !trip_q) begin
            sw_d = 1'b1;
            g_d  = load_val;
          end
        end
        OP_OVR_SET: ovr_d = 1'b1;
        OP_OVR_CLR: ovr_d = 1'b0;
        default: ;
      endcase
    end

    if (trip_now) begin
      sw_d   = 1'b0;
      g_d    = '0;
      trip_d = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_q   <= 1'b0;
      trip_q <= 1'b0;
      ovr_q  <= 1'b0;
      g_q    <= '0;
    end else begin
      sw_q   <= sw_d;
      trip_q <= trip_d;
      ovr_q  <= ovr_d;
      g_q    <= g_d;
    end
  end

  assign sw_en      = sw_q;
  assign tripped    = trip_q;
  assign ovr_on     = ovr_q;
  assign guard_busy = guard_live;

  assert_guard_only_when_on_R2: assert property (@(posedge clk) disable iff (!rst_n)
    guard_live |-> sw_q);

  assert_trip_forces_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(trip_q) |-> !sw_q && $past(sw_q));

  assert_guard_blocks_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
    guard_live |=> !$rose(trip_q));

  assert_override_blocks_trip_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ovr_q |=> !$rose(trip_q));

  assert_tripped_stays_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    trip_q |=> !$rose(sw_q));

  assert_off_cancels_guard_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_hit && cmd_op == OP_OFF) |=> (!sw_q && !guard_live));
endmodule

// File: rtl/pwr_switch_guard.sv
module pwr_switch_guard
  import pwrg_pkg::*;
#(
  parameter int N_INST      = 7,
  parameter int STEP_CYCLES = 167800,
  parameter int OC_RUN      = 4,
  localparam int SEL_W      = (N_INST > 1) ? $clog2(N_INST) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  input  logic [1:0]        cmd_op,
  input  logic [SEL_W-1:0]  cmd_sel,
  input  logic              len_wr,
  input  logic [GLEN_W-1:0] len_wdata,
  input  logic              trip_clr_wr,
  input  logic [N_INST-1:0] trip_clr_mask,
  input  logic [N_INST-1:0] oc_in,
  output logic [N_INST-1:0] sw_en,
  output logic [N_INST-1:0] tripped,
  output logic [N_INST-1:0] ovr_on,
  output logic [N_INST-1:0] guard_busy,
  output logic [GLEN_W-1:0] guard_len
);
  logic              rst_sn;
  logic [N_INST-1:0] oc_ok;
  logic [N_INST-1:0] hit;
  pwr_op_e           op;

  assign op = pwr_op_e'(cmd_op);

  pwrg_rst_sync u_rst (
    .clk    (clk),
    .rst_an (rst_n),
    .rst_sn (rst_sn)
  );

  pwrg_len_reg u_len (
    .clk   (clk),
    .rst_n (rst_sn),
    .wr_en (len_wr),
    .wdata (len_wdata),
    .len_q (guard_len)
  );

  for (genvar i = 0; i < N_INST; i++) begin : g_inst
    assign hit[i] = cmd_valid && (cmd_sel == SEL_W'(i));

    pwrg_oc_filter #(.RUN_LEN(OC_RUN)) u_filt (
      .clk          (clk),
      .rst_n        (rst_sn),
      .oc_async     (oc_in[i]),
      .oc_confirmed (oc_ok[i])
    );

    pwrg_channel #(.STEP_CYCLES(STEP_CYCLES)) u_chan (
      .clk        (clk),
      .rst_n      (rst_sn),
      .cmd_hit    (hit[i]),
      .cmd_op     (op),
      .clr_trip   (trip_clr_wr && trip_clr_mask[i]),
      .oc_ok      (oc_ok[i]),
      .len        (guard_len),
      .sw_en      (sw_en[i]),
      .tripped    (tripped[i]),
      .ovr_on     (ovr_on[i]),
      .guard_busy (guard_busy[i])
    );
  end

  assert_one_channel_hit_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    $onehot0(hit));

  assert_stray_sel_ignored_R10: assert property (@(posedge clk) disable iff (!rst_sn)
    (cmd_valid && (int'(cmd_sel) >= N_INST) && !trip_clr_wr && !len_wr && (oc_ok == '0))
      |=> ($countones(sw_en) <= $countones($past(sw_en))) && $stable(ovr_on));
endmodule

// File: tb/test_pwr_switch_guard.sv
module test_pwr_switch_guard;
  localparam int N    = 3;
  localparam int STEP = 5;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmd_valid;
  logic [1:0]   cmd_op;
  logic [1:0]   cmd_sel;
  logic         len_wr;
  logic [3:0]   len_wdata;
  logic         trip_clr_wr;
  logic [N-1:0] trip_clr_mask;
  logic [N-1:0] oc_in;
  logic [N-1:0] sw_en, tripped, ovr_on, guard_busy;
  logic [3:0]   guard_len;

  pwr_switch_guard #(.N_INST(N), .STEP_CYCLES(STEP), .OC_RUN(4)) i_pwr_switch_guard (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_sel(cmd_sel),
    .len_wr(len_wr), .len_wdata(len_wdata), .trip_clr_wr(trip_clr_wr),
    .trip_clr_mask(trip_clr_mask), .oc_in(oc_in), .sw_en(sw_en), .tripped(tripped),
    .ovr_on(ovr_on), .guard_busy(guard_busy), .guard_len(guard_len)
  );

  always #4 clk = ~clk;

  localparam int F_SW = 0, F_TRIP = 1, F_OVR = 2, F_GUARD = 3, F_LEN = 4;

  typedef struct {
    int          due;
    int          fld;
    int          bitn;
    logic [31:0] exp;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  int   t0;
  bit   done = 0;

  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [31:0] grab(int fld, int bitn);
    logic [31:0] v;
    case (fld)
      F_SW:    v = 32'(sw_en);
      F_TRIP:  v = 32'(tripped);
      F_OVR:   v = 32'(ovr_on);
      F_GUARD: v = 32'(guard_busy);
      default: v = 32'(guard_len);
    endcase
    if (bitn >= 0) v = 32'(v[bitn]);
    return v;
  endfunction

  task automatic expect_at(int due, int fld, int bitn, int val, string tag);
    exp_t e;
    e.due = due; e.fld = fld; e.bitn = bitn; e.exp = 32'(val); e.tag = tag;
    sb_q.push_back(e);
  endtask

  // monitor: pops every expectation whose edge has come
  always @(negedge clk) begin
    for (int k = sb_q.size() - 1; k >= 0; k--) begin
      if (sb_q[k].due <= cyc) begin
        logic [31:0] act;
        act = grab(sb_q[k].fld, sb_q[k].bitn);
        n_cmp++;
        if (sb_q[k].due != cyc || act !== sb_q[k].exp) begin
          n_bad++;
          $display("FAIL %s field %0d bit %0d cycle %0d: actual %0h expected %0h",
                   sb_q[k].tag, sb_q[k].fld, sb_q[k].bitn, cyc, act, sb_q[k].exp);
        end
        sb_q.delete(k);
      end
    end
  end

  task automatic wait_n(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic cmd_go(logic [1:0] op, logic [1:0] sel);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_op = op; cmd_sel = sel;
    t0 = cyc;
  endtask

  task automatic cmd_end();
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic len_write(logic [3:0] v, int expv);
    @(negedge clk);
    len_wr = 1'b1; len_wdata = v;
    expect_at(cyc + 1, F_LEN, -1, expv, "R3 clamp");
    @(negedge clk);
    len_wr = 1'b0;
  endtask

  task automatic clear_trips(logic [N-1:0] m);
    @(negedge clk);
    trip_clr_wr = 1'b1; trip_clr_mask = m;
    t0 = cyc;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00; cmd_sel = 2'd0;
    len_wr = 1'b0; len_wdata = 4'd0; trip_clr_wr = 1'b0; trip_clr_mask = '0; oc_in = '0;
    wait_n(3);
    rst_n = 1'b1;
    wait_n(4);

    // R1 reset state
    @(negedge clk);
    expect_at(cyc + 1, F_SW,    -1, 0,  "R1 switches");
    expect_at(cyc + 1, F_TRIP,  -1, 0,  "R1 trips");
    expect_at(cyc + 1, F_OVR,   -1, 0,  "R1 override");
    expect_at(cyc + 1, F_GUARD, -1, 0,  "R1 guard");
    expect_at(cyc + 1, F_LEN,   -1, 10, "R1 length");
    wait_n(2);

    // R3 length clamping
    len_write(4'd0, 1);
    len_write(4'd15, 10);
    len_write(4'd11, 10);
    len_write(4'd7, 7);
    len_write(4'd3, 3);

    // R2/R6 guardband with steady overcurrent on instrument 0 (G = 15)
    oc_in[0] = 1'b1;
    wait_n(8);
    cmd_go(2'b01, 2'd0);
    expect_at(t0 + 1,  F_SW,    0, 1, "R2 on");
    expect_at(t0 + 1,  F_GUARD, 0, 1, "R2 guard start");
    expect_at(t0 + 15, F_GUARD, 0, 1, "R2 guard last cycle");
    expect_at(t0 + 16, F_GUARD, 0, 0, "R2 guard end");
    expect_at(t0 + 16, F_SW,    0, 1, "R6 no trip in guard");
    expect_at(t0 + 17, F_SW,    0, 0, "R6 trip after guard");
    expect_at(t0 + 17, F_TRIP,  0, 1, "R6 trip flag");
    cmd_end();
    wait_n(20);

    // R8 refused while tripped, then cleared
    cmd_go(2'b01, 2'd0);
    expect_at(t0 + 1, F_SW, 0, 0, "R8 on refused");
    expect_at(t0 + 1, F_TRIP, 0, 1, "R8 flag sticky");
    cmd_end();
    oc_in[0] = 1'b0;
    wait_n(8);
    clear_trips(3'b001);
    expect_at(t0 + 1, F_TRIP, 0, 0, "R8 cleared");
    @(negedge clk);
    trip_clr_wr = 1'b0;
    cmd_go(2'b01, 2'd0);
    expect_at(t0 + 1, F_SW, 0, 1, "R8 on after clear");
    cmd_end();
    wait_n(3);

    // R9 off during guardband
    cmd_go(2'b00, 2'd0);
    expect_at(t0 + 1, F_SW,    0, 0, "R9 off");
    expect_at(t0 + 1, F_GUARD, 0, 0, "R9 guard cancelled");
    cmd_end();
    wait_n(3);

    // R4/R5 filter on instrument 1
    cmd_go(2'b01, 2'd1);
    cmd_end();
    wait_n(20);
    @(negedge clk);
    oc_in[1] = 1'b1;
    wait_n(3);
    oc_in[1] = 1'b0;
    wait_n(10);
    @(negedge clk);
    expect_at(cyc + 1, F_SW,   1, 1, "R4 glitch ignored");
    expect_at(cyc + 1, F_TRIP, 1, 0, "R4 glitch no trip");
    wait_n(2);
    @(negedge clk);
    oc_in[1] = 1'b1;
    t0 = cyc;
    expect_at(t0 + 6, F_SW,   1, 1, "R5 still on");
    expect_at(t0 + 7, F_SW,   1, 0, "R5 trip edge");
    expect_at(t0 + 7, F_TRIP, 1, 1, "R5 trip flag");
    expect_at(t0 + 7, F_TRIP, 0, 0, "R10 neighbour flag");
    wait_n(4);
    oc_in[1] = 1'b0;
    wait_n(10);

    // R7 override on instrument 2
    cmd_go(2'b10, 2'd2);
    expect_at(t0 + 1, F_OVR, -1, 3'b100, "R7 override set");
    cmd_end();
    cmd_go(2'b01, 2'd2);
    cmd_end();
    wait_n(20);
    oc_in[2] = 1'b1;
    wait_n(15);
    @(negedge clk);
    expect_at(cyc + 1, F_SW,   2, 1, "R7 held by override");
    expect_at(cyc + 1, F_TRIP, 2, 0, "R7 no trip");
    cmd_go(2'b11, 2'd2);
    expect_at(t0 + 1, F_OVR, 2, 0, "R7 override clear");
    expect_at(t0 + 1, F_SW,  2, 1, "R7 on until next edge");
    expect_at(t0 + 2, F_SW,  2, 0, "R7 trip after clear");
    expect_at(t0 + 2, F_TRIP, -1, 3'b110, "R7 R10 flags");
    cmd_end();
    wait_n(3);
    oc_in[2] = 1'b0;
    wait_n(8);

    // R10 stray index and per-bit clear
    clear_trips(3'b010);
    expect_at(t0 + 1, F_TRIP, -1, 3'b100, "R10 own bit only");
    @(negedge clk);
    trip_clr_wr = 1'b0;
    cmd_go(2'b01, 2'd3);
    expect_at(t0 + 1, F_SW,    -1, 0, "R10 stray on");
    expect_at(t0 + 1, F_GUARD, -1, 0, "R10 stray guard");
    cmd_end();
    cmd_go(2'b10, 2'd3);
    expect_at(t0 + 1, F_OVR, -1, 0, "R10 stray override");
    cmd_end();
    wait_n(4);

    done = 1;
    summary();
    $finish;
  end
endmodule